// File: doc/BRIEF.md
# Coprocessor issue queue with transfer interlocks

This block is the issue stage of a single-issue integer pipeline that forwards media and floating-point operations to a separate coprocessor. Each forwarded operation goes into an in-order queue for its class, one for media and one for floating point. A fixed-latency execution model drains each queue, one operation at a time. An integer instruction that finds its target queue full holds the integer side until an entry frees.

The block also paces register transfers between the integer and coprocessor register files. An integer-to-media transfer waits until no queued or executing media operation uses its destination register, and until no other such transfer is still in flight. A word-insert variant also takes a short window of execution time away from the coprocessor. A media-to-integer transfer waits until its source register has been produced, then occupies the integer side for a fixed window while the media queue keeps draining.

Top module: `cop_issue_q`

## Requirements
- R1: A synchronous active-high reset empties both queues, stops both execution units, and clears all transfer occupancy and steal state. After reset, `stall`, `mq_level`, `fq_level`, `mq_full`, `fq_full` and `steal_active` are all 0, and an integer-to-media transfer issues without waiting.
- R2: The media queue holds MQ_D (6) entries. `mq_full` is registered on the same edge as the push that fills the queue. While `mq_full` is high, a media operation raises `stall` and waits.
- R3: The floating-point queue holds FQ_D (4) entries. `fq_full` is registered on the push that fills the queue, and a floating-point operation stalls while `fq_full` is high.
- R4: Each queue retires in order. A queue pops its head only when its unit is idle. The media unit stays busy for M_LAT cycles after the pop cycle, so back-to-back media pops are M_LAT+1 cycles apart; the floating-point unit uses F_LAT in the same way. Pushes into one queue never change the level of the other.
- R5: An integer-to-media transfer (move or word insert) stalls while any queued or executing media operation reads or writes its destination register. A transfer whose destination is unrelated to the queued and executing media operations issues at once.
- R6: Only one integer-to-media transfer is in flight at a time, whatever registers it uses. A second one stalls through the first one's occupancy and through its steal window.
- R7: A plain integer-to-media move occupies the integer side for IN_OCC (5) cycles, counting its issue cycle, and starts no steal window.
- R8: A word insert occupies the integer side for IN_OCC cycles. In the 4 (STEAL) cycles after that, `steal_active` is high and neither queue pops or advances its execution.
- R9: A media-to-integer transfer stalls until no queued or executing media operation writes its source register. It then occupies the integer side for OUT_OCC (10) cycles, counting its issue cycle, and the media queue keeps draining during that window.
- R10: An ordinary media operation is accepted right after an integer-to-media transfer's occupancy ends, even while the steal window is active, as long as the media queue is not full.
- R11: `in_cls` codes are: 0 integer, 1 media, 2 floating point, 3 integer-to-media move, 4 integer-to-media word insert, 5 media-to-integer transfer, and 6 or 7 treated as integer. `stall` is high whenever the integer side is occupied, and otherwise when the valid instruction's class is blocked. An instruction issues in a cycle with `in_valid` high and `stall` low, and in that cycle `issue_fire` is high and `issue_cls` carries its class. Plain integer instructions issue one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_cls | input | 3 | Instruction class (encoding in R11) |
| in_src | input | RW | Source register index |
| in_dst | input | RW | Destination register index |
| stall | output | 1 | Integer side held this cycle |
| issue_fire | output | 1 | Offered instruction issues this cycle |
| issue_cls | output | 3 | Class of the issuing instruction |
| mq_push | output | 1 | Media queue push event |
| mq_pop | output | 1 | Media queue pop event |
| fq_push | output | 1 | Floating-point queue push event |
| fq_pop | output | 1 | Floating-point queue pop event |
| mq_full | output | 1 | Media queue full (registered) |
| fq_full | output | 1 | Floating-point queue full (registered) |
| mq_level | output | clog2(MQ_D+1) | Media queue occupancy |
| fq_level | output | clog2(FQ_D+1) | Floating-point queue occupancy |
| steal_active | output | 1 | Word-insert steal window in progress |

## Verification
The bench keeps the default queue depths (6 and 4), the default occupancies (5 and 10 cycles) and the default steal window of 4. It shortens the execution latencies to M_LAT=3 and F_LAT=4. With these latencies, filling a queue, waiting for a dependency to clear and the freeze during a steal window each take only a few cycles, so every stall has a small exact count that the bench works out by hand. The short latencies also mean a media operation finishes well inside the 10-cycle media-to-integer window, which lets the bench show that the media queue keeps draining during that window.

// File: rtl/cop_issue_q.sv
module cop_issue_q #(
  parameter int MQ_D    = 6,
  parameter int FQ_D    = 4,
  parameter int RW      = 3,
  parameter int M_LAT   = 6,
  parameter int F_LAT   = 7,
  parameter int IN_OCC  = 5,
  parameter int OUT_OCC = 10,
  parameter int STEAL   = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [2:0]                  in_cls,
  input  logic [RW-1:0]               in_src,
  input  logic [RW-1:0]               in_dst,
  output logic                        stall,
  output logic                        issue_fire,
  output logic [2:0]                  issue_cls,
  output logic                        mq_push,
  output logic                        mq_pop,
  output logic                        fq_push,
  output logic                        fq_pop,
  output logic                        mq_full,
  output logic                        fq_full,
  output logic [$clog2(MQ_D+1)-1:0]   mq_level,
  output logic [$clog2(FQ_D+1)-1:0]   fq_level,
  output logic                        steal_active
);
  localparam int MCW = $clog2(MQ_D + 1);
  localparam int FCW = $clog2(FQ_D + 1);
  localparam int IW  = $clog2(MQ_D);
  localparam int MLW = $clog2(M_LAT + 1);
  localparam int FLW = $clog2(F_LAT + 1);
  localparam int HW  = $clog2((OUT_OCC > IN_OCC ? OUT_OCC : IN_OCC) + 1);
  localparam int SW  = $clog2(STEAL + 1);

  localparam logic [2:0] C_MED  = 3'd1;
  localparam logic [2:0] C_FP   = 3'd2;
  localparam logic [2:0] C_MOVI = 3'd3;
  localparam logic [2:0] C_INSW = 3'd4;
  localparam logic [2:0] C_MOVO = 3'd5;

  logic [MCW-1:0] mq_cnt, m_nxt;
  logic [FCW-1:0] fq_cnt, f_nxt;
  logic [RW-1:0]  mq_src [MQ_D];
  logic [RW-1:0]  mq_dst [MQ_D];
  logic [RW-1:0]  nq_src [MQ_D];
  logic [RW-1:0]  nq_dst [MQ_D];
  logic [MLW-1:0] mexec;
  logic [FLW-1:0] fexec;
  logic [RW-1:0]  mx_src, mx_dst;
  logic [HW-1:0]  hold;
  logic [SW-1:0]  steal;
  logic           ins_pend;
  logic           m_touch, m_pendw, hz, accept;
  logic [IW-1:0]  widx;

  always_comb begin
    m_touch = (mexec != '0) && (mx_src == in_dst || mx_dst == in_dst);
    m_pendw = (mexec != '0) && (mx_dst == in_src);
    for (int i = 0; i < MQ_D; i++) begin
      if (MCW'(i) < mq_cnt) begin
        if (mq_src[i] == in_dst || mq_dst[i] == in_dst) m_touch = 1'b1;
        if (mq_dst[i] == in_src) m_pendw = 1'b1;
      end
    end
  end

  always_comb begin
    case (in_cls)
      C_MED:          hz = mq_full;
      C_FP:           hz = fq_full;
      C_MOVI, C_INSW: hz = m_touch || (steal != '0);
      C_MOVO:         hz = m_pendw;
      default:        hz = 1'b0;
    endcase
  end

  assign stall        = (hold != '0) || (in_valid && hz);
  assign accept       = in_valid && !stall;
  assign issue_fire   = accept;
  assign issue_cls    = in_cls;
  assign mq_push      = accept && in_cls == C_MED;
  assign fq_push      = accept && in_cls == C_FP;
  assign mq_pop       = (mq_cnt != '0) && (mexec == '0) && (steal == '0);
  assign fq_pop       = (fq_cnt != '0) && (fexec == '0) && (steal == '0);
  assign m_nxt        = mq_cnt + MCW'(mq_push) - MCW'(mq_pop);
  assign f_nxt        = fq_cnt + FCW'(fq_push) - FCW'(fq_pop);
  assign mq_level     = mq_cnt;
  assign fq_level     = fq_cnt;
  assign steal_active = (steal != '0);
  assign widx         = IW'(mq_cnt - MCW'(mq_pop));

  always_comb begin
    for (int i = 0; i < MQ_D; i++) begin
      nq_src[i] = mq_src[i];
      nq_dst[i] = mq_dst[i];
    end
    if (mq_pop) begin
      for (int i = 0; i < MQ_D - 1; i++) begin
        nq_src[i] = mq_src[i+1];
        nq_dst[i] = mq_dst[i+1];
      end
    end
    if (mq_push) begin
      nq_src[widx] = in_src;
      nq_dst[widx] = in_dst;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < MQ_D; i++) begin
      mq_src[i] <= nq_src[i];
      mq_dst[i] <= nq_dst[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mq_cnt  <= '0;
      fq_cnt  <= '0;
      mq_full <= 1'b0;
      fq_full <= 1'b0;
    end else begin
      mq_cnt  <= m_nxt;
      fq_cnt  <= f_nxt;
      mq_full <= (m_nxt == MCW'(MQ_D));
      fq_full <= (f_nxt == FCW'(FQ_D));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mexec  <= '0;
      fexec  <= '0;
      mx_src <= '0;
      mx_dst <= '0;
    end else begin
      if (mq_pop) begin
        mexec  <= MLW'(M_LAT);
        mx_src <= mq_src[0];
        mx_dst <= mq_dst[0];
      end else if (mexec != '0 && steal == '0) begin
        mexec <= mexec - MLW'(1);
      end
      if (fq_pop) fexec <= FLW'(F_LAT);
      else if (fexec != '0 && steal == '0) fexec <= fexec - FLW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      steal    <= '0;
      ins_pend <= 1'b0;
    end else begin
      if (accept && (in_cls == C_MOVI || in_cls == C_INSW)) hold <= HW'(IN_OCC - 1);
      else if (accept && in_cls == C_MOVO)                 hold <= HW'(OUT_OCC - 1);
      else if (hold != '0)                                 hold <= hold - HW'(1);

      if (accept && in_cls == C_INSW) ins_pend <= 1'b1;
      else if (hold == HW'(1))        ins_pend <= 1'b0;

      if (hold == HW'(1) && ins_pend) steal <= SW'(STEAL);
      else if (steal != '0)           steal <= steal - SW'(1);
    end
  end

  // R2
  mq_full_chk: assert property (@(posedge clk) disable iff (rst)
    mq_full == (mq_cnt == MCW'(MQ_D)));

  // R3
  fq_full_chk: assert property (@(posedge clk) disable iff (rst)
    fq_full == (fq_cnt == FCW'(FQ_D)));

  // R4
  mq_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (mq_push && !mq_pop) |=> (mq_cnt == $past(mq_cnt) + MCW'(1)));

  // R6
  hold_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (hold != '0) |-> stall);

  // R8
  steal_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    steal_active |-> (!mq_pop && !fq_pop));

  // R9
  out_window_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && in_cls == C_MOVO) |=> (hold == HW'(OUT_OCC - 1)));
endmodule

// File: tb/cop_issue_q_tb.sv
module cop_issue_q_tb;
  localparam int CLK_P = 10;
  localparam int RW    = 3;

  localparam logic [2:0] C_INT  = 3'd0;
  localparam logic [2:0] C_MED  = 3'd1;
  localparam logic [2:0] C_FP   = 3'd2;
  localparam logic [2:0] C_MOVI = 3'd3;
  localparam logic [2:0] C_INSW = 3'd4;
  localparam logic [2:0] C_MOVO = 3'd5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_cls = '0;
  logic [RW-1:0] in_src = '0;
  logic [RW-1:0] in_dst = '0;
  logic          stall, issue_fire, mq_push, mq_pop, fq_push, fq_pop;
  logic          mq_full, fq_full, steal_active;
  logic [2:0]    issue_cls;
  logic [2:0]    mq_level;
  logic [2:0]    fq_level;

  cop_issue_q #(.MQ_D(6), .FQ_D(4), .RW(RW), .M_LAT(3), .F_LAT(4),
                .IN_OCC(5), .OUT_OCC(10), .STEAL(4)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls),
    .in_src(in_src), .in_dst(in_dst), .stall(stall), .issue_fire(issue_fire),
    .issue_cls(issue_cls), .mq_push(mq_push), .mq_pop(mq_pop),
    .fq_push(fq_push), .fq_pop(fq_pop), .mq_full(mq_full), .fq_full(fq_full),
    .mq_level(mq_level), .fq_level(fq_level), .steal_active(steal_active));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string req_q[$];
  int    waitc = 0;

  task automatic chk(int act, int exp, string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: counts stall cycles of the offered instruction, compares at issue
  always @(negedge clk) begin
    if (!rst && in_valid) begin
      if (stall) waitc++;
      else begin
        chk(int'(issue_fire), 1, "R11");
        chk(int'(issue_cls), int'(in_cls), "R11");
        if (exp_q.size() == 0) chk(waitc, -1, "R11");
        else chk(waitc, exp_q.pop_front(), req_q.pop_front());
        waitc = 0;
      end
    end
  end

  task automatic send(logic [2:0] c, int s, int d, int exp_wait, string req);
    exp_q.push_back(exp_wait);
    req_q.push_back(req);
    in_valid = 1'b1;
    in_cls   = c;
    in_src   = RW'(s);
    in_dst   = RW'(d);
    do @(negedge clk); while (stall);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    chk(exp_q.size(), 0, "R11");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++;
    errors++;
    $display("FAIL R11 watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(int'(stall), 0, "R1");
    chk(int'(mq_level), 0, "R1");
    chk(int'(fq_level), 0, "R1");
    chk(int'(mq_full), 0, "R1");
    chk(int'(steal_active), 0, "R1");
    @(posedge clk); #1;

    // R11: plain integer stream, one per clock
    send(C_INT, 0, 0, 0, "R11");
    send(C_INT, 1, 2, 0, "R11");
    send(7, 0, 0, 0, "R11");

    // R2: fill media queue
    for (int i = 0; i < 8; i++) send(C_MED, 1, 1, 0, "R2");
    chk(int'(mq_full), 1, "R2");
    chk(int'(mq_level), 6, "R2");
    chk(int'(fq_level), 0, "R4");
    send(C_MED, 1, 1, 2, "R2");
    idle(40);
    chk(int'(mq_level), 0, "R4");

    // R4: pop spacing
    send(C_MED, 0, 1, 0, "R4");
    send(C_MED, 0, 2, 0, "R4");
    n = 0;
    @(negedge clk);
    while (!mq_pop && n < 50) begin n++; @(negedge clk); end
    chk(n, 3, "R4");
    idle(20);

    // R3: fill fp queue
    for (int i = 0; i < 5; i++) send(C_FP, 0, 0, 0, "R3");
    chk(int'(fq_full), 1, "R3");
    chk(int'(fq_level), 4, "R3");
    chk(int'(mq_level), 0, "R4");
    send(C_FP, 0, 0, 2, "R3");
    idle(40);
    chk(int'(fq_level), 0, "R3");

    // R7: plain move occupancy, no steal
    send(C_MOVI, 0, 2, 0, "R7");
    send(C_INT, 0, 0, 4, "R7");
    send(C_MOVI, 0, 3, 0, "R7");
    send(C_INT, 0, 0, 4, "R7");
    idle(20);

    // R6: second transfer waits through insert occupancy and steal
    send(C_INSW, 0, 2, 0, "R8");
    @(negedge clk);
    chk(int'(stall), 1, "R11");
    @(posedge clk); #1;
    send(C_MOVI, 0, 5, 7, "R6");
    idle(20);

    // R8 / R10: steal window freezes pops, media op still accepted
    send(C_INSW, 0, 2, 0, "R8");
    send(C_INT, 0, 0, 4, "R8");
    send(C_MED, 0, 6, 0, "R10");
    chk(int'(steal_active), 1, "R8");
    chk(int'(mq_level), 1, "R8");
    idle(2);
    chk(int'(mq_level), 1, "R8");
    idle(1);
    chk(int'(mq_level), 0, "R8");
    chk(int'(steal_active), 0, "R8");
    idle(20);

    // R5: dependency on destination, on source, and independent
    send(C_MED, 0, 4, 0, "R5");
    send(C_MOVI, 0, 4, 4, "R5");
    idle(20);
    send(C_MED, 6, 7, 0, "R5");
    send(C_MOVI, 0, 6, 4, "R5");
    idle(20);
    send(C_MED, 0, 4, 0, "R5");
    send(C_MOVI, 0, 5, 0, "R5");
    idle(20);

    // R9: media-to-integer waits for source, then 10-cycle window
    send(C_MED, 0, 3, 0, "R9");
    send(C_MED, 0, 1, 0, "R9");
    send(C_MED, 0, 2, 0, "R9");
    send(C_MOVO, 3, 0, 2, "R9");
    chk(int'(mq_level), 1, "R9");
    send(C_INT, 0, 0, 9, "R9");
    chk(int'(mq_level), 0, "R9");
    idle(20);
    send(C_MOVO, 5, 0, 0, "R9");
    idle(20);

    // R1: reset mid-activity
    send(C_MED, 1, 1, 0, "R1");
    send(C_MED, 1, 1, 0, "R1");
    send(C_MED, 1, 1, 0, "R1");
    send(C_INSW, 0, 6, 0, "R1");
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    chk(int'(mq_level), 0, "R1");
    chk(int'(fq_level), 0, "R1");
    chk(int'(mq_full), 0, "R1");
    chk(int'(steal_active), 0, "R1");
    @(negedge clk);
    chk(int'(stall), 0, "R1");
    @(posedge clk); #1;
    send(C_MOVI, 0, 1, 0, "R1");
    idle(5);

    finish_run();
  end
endmodule